// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the read port of an instruction cache and a decoder for variable-length instructions. It asks the cache for one aligned 16-byte block at a time and keeps the returned bytes in program order in a 48-byte ring. The oldest bytes are shown to the decoder as a window of up to 15 bytes, together with a count of how many of them are valid. Each cycle the decoder states the length of the instruction at the front of the window. When that many bytes are present they are removed in the same cycle. Otherwise decode waits.

A redirect input carries a predicted branch target. In the cycle it is raised, the cache request goes out for the block that holds the target. Everything queued is dropped, and so is the block that was still on its way back. The first block of the new stream enters the queue without the bytes that lie below the target. Outside a redirect, a new block is requested whenever the ring has room for a whole block once the pending return is counted. This keeps the byte stream continuous. The cache contract is fixed: every request is answered exactly one cycle later.

Top module: `ifetch_byte_queue`

## Requirements
- R1: After reset the window holds no valid bytes, nothing is consumed, and a fetch request for the block at the reset address (default 0) is raised.
- R2: Outside a redirect, a fetch request is raised exactly when the held byte count, plus 16 if a block is due back this cycle, plus 16 is at most 48.
- R3: Request addresses have their low four bits zero, and each request that is not a redirect asks for the block 16 bytes above the previous request.
- R4: A returned block is appended behind the queued bytes in address order. Byte k of the block is taken from fetch data bits [8k+7:8k].
- R5: The window count equals the lesser of the held byte count and 15. Window byte j, at bits [8j+7:8j], is the j-th oldest held byte.
- R6: A decode length L with 1 <= L <= window count removes the L oldest bytes and raises the take flag in that cycle. A length of 0 or above the window count removes nothing and leaves the take flag low.
- R7: A redirect raises a fetch request for the target rounded down to 16 in the same cycle. It discards the queue contents, any block returned in that cycle and any decode length, so the window count is 0 in the next cycle.
- R8: The first block after a redirect contributes only its bytes from the target's low four bits upward.
- R9: The held byte count never exceeds 48. With decode stalled, the queue fills to 48 and requests stop.
- R10: An append and a removal in the same cycle both take effect, and byte order is kept across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect to a predicted target this cycle |
| redir_addr | input | ADDR_W | Byte address of the redirect target |
| fetch_req_valid | output | 1 | Cache block request |
| fetch_req_addr | output | ADDR_W | Aligned block address of the request |
| fetch_rsp_valid | input | 1 | Cache returns the block requested one cycle earlier |
| fetch_rsp_data | input | FETCH_BYTES*8 | Returned block, lowest address in the low byte |
| win_data | output | WIN_BYTES*8 | Oldest bytes, oldest in the low byte |
| win_count | output | $clog2(WIN_BYTES+1) | Number of valid window bytes |
| dec_len | input | $clog2(WIN_BYTES+1) | Length of the instruction at the window front, 0 for none |
| dec_take | output | 1 | Bytes of dec_len removed this cycle |

## Verification
The window, the window count, the take flag and the fetch request are combinational functions of the stored state and the inputs of the same cycle. The bench therefore drives inputs on the falling edge and compares these values a moment later, before the next rising edge. Removals, appends and a redirect flush show up in the window one rising edge later. A cache block arrives one cycle after its request, so its bytes become visible two edges after the request. The bench's model of the queue advances at each rising edge with the same inputs, so every comparison lines up with these delays.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef logic [7:0] qbyte_t;

  // Sum of two ring positions folded back into [0, depth).
  function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                           int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Forward distance from tail to slot on a ring of the given depth.
  function automatic int unsigned ring_dist(int unsigned slot, int unsigned tail,
                                            int unsigned depth);
    return (slot >= tail) ? slot - tail : slot + depth - tail;
  endfunction

  // True when one more block fits once the pending return is counted.
  function automatic bit block_fits(int unsigned level, bit pending,
                                    int unsigned blk, int unsigned depth);
    return (level + (pending ? blk : 0) + blk) <= depth;
  endfunction

  // Number of bytes visible in the decode window.
  function automatic int unsigned window_fill(int unsigned level, int unsigned win);
    return (level < win) ? level : win;
  endfunction

endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned QUEUE_BYTES = 48,
  parameter logic [ADDR_W-1:0] RESET_BLOCK_ADDR = '0,
  localparam int unsigned OFF_W = $clog2(FETCH_BYTES),
  localparam int unsigned CNT_W = $clog2(QUEUE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic [CNT_W-1:0]  level,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              inflight,
  output logic [OFF_W-1:0]  skip
);

  logic [ADDR_W-1:0] pc_q;
  logic              infl_q;
  logic [OFF_W-1:0]  skip_q;
  logic              room_ok;

  function automatic logic [ADDR_W-1:0] align_down(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  always_comb room_ok = block_fits(32'(level), infl_q, FETCH_BYTES, QUEUE_BYTES);

  assign req_valid = redir_valid | room_ok;
  assign req_addr  = redir_valid ? align_down(redir_addr) : pc_q;
  assign inflight  = infl_q;
  assign skip      = skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= align_down(RESET_BLOCK_ADDR);
      infl_q <= 1'b0;
      skip_q <= '0;
    end else begin
      infl_q <= req_valid;
      skip_q <= redir_valid ? redir_addr[OFF_W-1:0] : '0;
      if (req_valid) pc_q <= req_addr + ADDR_W'(FETCH_BYTES);
    end
  end

  // R3: consecutive requests outside a redirect walk forward one block.
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 (req_valid && !redir_valid) |-> req_addr == $past(req_addr) + ADDR_W'(FETCH_BYTES));

  // R2: no request when a further block could not be stored.
  p_no_req_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && 32'(level) + FETCH_BYTES > QUEUE_BYTES) |-> !req_valid);

endmodule

// File: rtl/pfq_block_align.sv
module pfq_block_align
  import pfq_pkg::*;
#(
  parameter int unsigned FETCH_BYTES = 16,
  localparam int unsigned OFF_W = $clog2(FETCH_BYTES),
  localparam int unsigned ENQ_W = $clog2(FETCH_BYTES + 1)
) (
  input  logic [FETCH_BYTES*8-1:0] blk_in,
  input  logic [OFF_W-1:0]         skip,
  output logic [FETCH_BYTES*8-1:0] blk_out,
  output logic [ENQ_W-1:0]         blk_n
);

  always_comb begin
    for (int k = 0; k < FETCH_BYTES; k++) begin
      int unsigned idx;
      idx = k + 32'(skip);
      if (idx < FETCH_BYTES) blk_out[8*k +: 8] = blk_in[8*idx +: 8];
      else                   blk_out[8*k +: 8] = '0;
    end
    blk_n = ENQ_W'(FETCH_BYTES - 32'(skip));
  end

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH       = 48,
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned WIN_BYTES   = 15,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned ENQ_W = $clog2(FETCH_BYTES + 1),
  localparam int unsigned SEL_W = $clog2(FETCH_BYTES),
  localparam int unsigned DEQ_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     enq_valid,
  input  logic [ENQ_W-1:0]         enq_n,
  input  logic [FETCH_BYTES*8-1:0] enq_bytes,
  input  logic [DEQ_W-1:0]         deq_n,
  output logic [CNT_W-1:0]         level,
  output logic [WIN_BYTES*8-1:0]   win_data,
  output logic [DEQ_W-1:0]         win_count
);

  qbyte_t            mem [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  level_q;
  logic [DEPTH-1:0]  wr_en;
  logic [SEL_W-1:0]  wr_sel [DEPTH];
  int unsigned       tail;

  always_comb begin
    tail = ring_add(32'(head_q), 32'(level_q), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      int unsigned d;
      d         = ring_dist(i, tail, DEPTH);
      wr_en[i]  = enq_valid && !flush && (d < 32'(enq_n));
      wr_sel[i] = SEL_W'(d);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_en[i]) mem[i] <= enq_bytes[8*wr_sel[i] +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      level_q <= '0;
    end else begin
      head_q  <= PTR_W'(ring_add(32'(head_q), 32'(deq_n), DEPTH));
      level_q <= level_q - CNT_W'(deq_n) + (enq_valid ? CNT_W'(enq_n) : '0);
    end
  end

  for (genvar j = 0; j < WIN_BYTES; j++) begin : g_win
    assign win_data[8*j +: 8] = mem[PTR_W'(ring_add(32'(head_q), j, DEPTH))];
  end

  assign win_count = DEQ_W'(window_fill(32'(level_q), WIN_BYTES));
  assign level     = level_q;

  // R9: what is stored after this edge never exceeds the ring.
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !flush) |-> 32'(level_q) + 32'(enq_n) - 32'(deq_n) <= DEPTH);

  // R6: removal never takes more than is held.
  p_deq_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(deq_n) <= 32'(level_q));

endmodule

// File: rtl/ifetch_byte_queue.sv
module ifetch_byte_queue
  import pfq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned QUEUE_BYTES = 48,
  parameter int unsigned WIN_BYTES   = 15,
  parameter logic [ADDR_W-1:0] RESET_BLOCK_ADDR = '0,
  localparam int unsigned DEQ_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redir_valid,
  input  logic [ADDR_W-1:0]        redir_addr,
  output logic                     fetch_req_valid,
  output logic [ADDR_W-1:0]        fetch_req_addr,
  input  logic                     fetch_rsp_valid,
  input  logic [FETCH_BYTES*8-1:0] fetch_rsp_data,
  output logic [WIN_BYTES*8-1:0]   win_data,
  output logic [DEQ_W-1:0]         win_count,
  input  logic [DEQ_W-1:0]         dec_len,
  output logic                     dec_take
);

  localparam int unsigned CNT_W = $clog2(QUEUE_BYTES + 1);
  localparam int unsigned OFF_W = $clog2(FETCH_BYTES);
  localparam int unsigned ENQ_W = $clog2(FETCH_BYTES + 1);

  logic [CNT_W-1:0]         level;
  logic                     inflight;
  logic [OFF_W-1:0]         skip;
  logic                     rsp_accept;
  logic [FETCH_BYTES*8-1:0] blk_aligned;
  logic [ENQ_W-1:0]         blk_n;
  logic [DEQ_W-1:0]         deq_n;

  pfq_fetch_ctrl #(
    .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES), .QUEUE_BYTES(QUEUE_BYTES),
    .RESET_BLOCK_ADDR(RESET_BLOCK_ADDR)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .level(level), .req_valid(fetch_req_valid), .req_addr(fetch_req_addr),
    .inflight(inflight), .skip(skip)
  );

  pfq_block_align #(.FETCH_BYTES(FETCH_BYTES)) u_align (
    .blk_in(fetch_rsp_data), .skip(skip), .blk_out(blk_aligned), .blk_n(blk_n)
  );

  assign rsp_accept = fetch_rsp_valid && !redir_valid;
  assign dec_take   = !redir_valid && (dec_len != '0) && (dec_len <= win_count);
  assign deq_n      = dec_take ? dec_len : '0;

  pfq_byte_ring #(
    .DEPTH(QUEUE_BYTES), .FETCH_BYTES(FETCH_BYTES), .WIN_BYTES(WIN_BYTES)
  ) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid), .enq_valid(rsp_accept),
    .enq_n(blk_n), .enq_bytes(blk_aligned), .deq_n(deq_n), .level(level),
    .win_data(win_data), .win_count(win_count)
  );

  // R4: a block only comes back for a request made one cycle earlier.
  p_rsp_contract_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rsp_valid |-> inflight);

  // R7: the cycle after a redirect starts from an empty queue.
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> win_count == '0);

  // R6: a take with no append lowers the held count by exactly the length.
  p_take_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && !rsp_accept) |=> 32'(level) == 32'($past(level)) - 32'($past(dec_len)));

  // R10: an append together with a take nets the two amounts.
  p_both_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && rsp_accept) |=>
      32'(level) == 32'($past(level)) + 32'($past(blk_n)) - 32'($past(dec_len)));

endmodule

// File: tb/ifetch_byte_queue_tb_top.sv
module ifetch_byte_queue_tb_top;

  localparam int FB = 16;
  localparam int QB = 48;
  localparam int WB = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          redir_valid;
  logic [31:0]   redir_addr;
  logic          fetch_req_valid;
  logic [31:0]   fetch_req_addr;
  logic          fetch_rsp_valid;
  logic [127:0]  fetch_rsp_data;
  logic [119:0]  win_data;
  logic [3:0]    win_count;
  logic [3:0]    dec_len;
  logic          dec_take;

  always #4 clk = ~clk;

  ifetch_byte_queue dut_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .fetch_req_valid(fetch_req_valid), .fetch_req_addr(fetch_req_addr),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
    .win_data(win_data), .win_count(win_count), .dec_len(dec_len), .dec_take(dec_take)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // behavioural model state
  byte unsigned mq[$];
  bit           m_infl;
  logic [31:0]  m_pc, m_pend;
  int           m_skip;
  // cache model
  bit           c_valid;
  logic [31:0]  c_addr;
  // stimulus
  bit           s_redir;
  logic [31:0]  s_raddr;
  int           s_len;
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  function automatic logic [7:0] cache_byte(logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, compare, advance model at the rising edge.
  task automatic step();
    bit          exp_req, exp_take, ok;
    logic [31:0] exp_addr;
    int          exp_wc;
    logic [119:0] exp_w, act_w;
    bit          c_nv;
    logic [31:0] c_na;
    redir_valid     = s_redir;
    redir_addr      = s_raddr;
    dec_len         = 4'(s_len);
    fetch_rsp_valid = c_valid;
    for (int k = 0; k < FB; k++) fetch_rsp_data[8*k +: 8] = cache_byte(c_addr + 32'(k));
    #1;
    exp_req  = s_redir || (mq.size() + (m_infl ? FB : 0) + FB <= QB);
    exp_addr = s_redir ? (s_raddr & ~32'hF) : m_pc;
    exp_wc   = (mq.size() < WB) ? mq.size() : WB;
    exp_take = !s_redir && s_len != 0 && s_len <= exp_wc;
    chk(fetch_req_valid === exp_req, "R2", "request", 128'(fetch_req_valid), 128'(exp_req));
    if (exp_req)
      chk(fetch_req_addr === exp_addr, s_redir ? "R7" : "R3", "request address",
          128'(fetch_req_addr), 128'(exp_addr));
    chk(win_count === 4'(exp_wc), "R5", "window count", 128'(win_count), 128'(exp_wc));
    chk(dec_take === exp_take, "R6", "take flag", 128'(dec_take), 128'(exp_take));
    exp_w = '0; act_w = '0; ok = 1'b1;
    for (int j = 0; j < exp_wc; j++) begin
      exp_w[8*j +: 8] = mq[j];
      act_w[8*j +: 8] = win_data[8*j +: 8];
      if (win_data[8*j +: 8] !== 8'(mq[j])) ok = 1'b0;
    end
    chk(ok, "R4 R8 R10", "window bytes", 128'(act_w), 128'(exp_w));
    c_nv = fetch_req_valid;
    c_na = fetch_req_addr;
    @(posedge clk);
    c_valid = c_nv;
    c_addr  = c_na;
    if (s_redir) begin
      mq.delete();
      m_infl = 1'b1;
      m_pend = exp_addr;
      m_pc   = exp_addr + 32'(FB);
      m_skip = int'(s_raddr[3:0]);
    end else begin
      if (exp_take) for (int j = 0; j < s_len; j++) void'(mq.pop_front());
      if (m_infl) for (int k = m_skip; k < FB; k++) mq.push_back(cache_byte(m_pend + 32'(k)));
      m_infl = exp_req;
      if (exp_req) begin
        m_pend = m_pc;
        m_pc   = m_pc + 32'(FB);
      end
      m_skip = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; redir_valid = 1'b0; redir_addr = '0; dec_len = '0;
    fetch_rsp_valid = 1'b0; fetch_rsp_data = '0;
    m_infl = 1'b0; m_pc = '0; m_pend = '0; m_skip = 0;
    c_valid = 1'b0; c_addr = '0;
    s_redir = 1'b0; s_raddr = '0; s_len = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(win_count === 4'd0, "R1", "reset window count", 128'(win_count), 128'(0));
    chk(fetch_req_valid === 1'b1, "R1", "reset request", 128'(fetch_req_valid), 128'(1));
    chk(fetch_req_addr === 32'h0, "R1", "reset address", 128'(fetch_req_addr), 128'(0));
    chk(dec_take === 1'b0, "R1", "reset take", 128'(dec_take), 128'(0));

    // varied lengths with aligned and unaligned redirects (R6, R8, R10)
    for (int c = 0; c < 150; c++) begin
      s_redir = (c == 60) || (c == 100);
      s_raddr = (c == 60) ? 32'h0000_1000 : 32'h0000_2347;
      s_len   = (c * 5 + 3) % 16;
      step();
    end
    // decoder stalled: fill to capacity (R9)
    s_redir = 1'b0; s_len = 0;
    for (int c = 0; c < 40; c++) step();
    chk(fetch_req_valid === 1'b0 && win_count === 4'd15, "R9", "full queue holds requests",
        128'({fetch_req_valid, win_count}), 128'({1'b0, 4'd15}));
    // redirect while full with a take ignored, then back to back (R7)
    s_redir = 1'b1; s_raddr = 32'h0000_500F; s_len = 3; step();
    s_redir = 1'b1; s_raddr = 32'hFFFF_FFF9; s_len = 1; step();
    s_redir = 1'b0; s_len = 0; step();
    // mixed random traffic
    for (int c = 0; c < 1200; c++) begin
      lfsr    = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s_redir = (lfsr[4:0] == 5'd0);
      s_raddr = {lfsr[7:0], lfsr[31:8]};
      s_len   = int'(lfsr[11:8]);
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule